// File: doc/BRIEF.md
# NAND-style ROM command/address front end

This block is the device-side interface logic of a read-only memory that is reached over a NAND-style byte bus. It samples the bus on each rising edge of the active-low write strobe, but only while chip select is low. The command and address latch enables decide whether the byte is a command or an address. A read command chooses which part of a 528-byte page is read: the lower 256-byte half, the upper 256-byte half, or the 16-byte spare tail. A reset opcode brings the block back to idle.

After a read command, three address bytes are collected. The first byte gives the column offset. The second and third bytes give the low and high halves of a 16-bit page index. When the last byte is in, the block raises a one-clock start request towards the read engine. At that point the decoded mode, the absolute start column and the page index are already on the outputs. A busy input from the read engine blocks everything except the reset opcode.

The write strobe is a plain input that is sampled in the block clock domain. A rising edge is seen when the strobe is low at one clock edge and high at the next. All outputs are registered, so they change at the clock edge that sees the rising edge.

Top module: `nrom_cmd_front`

## Requirements
- R1: A byte is taken only at a clock edge where `we_n` is high, `we_n` was low at the previous edge, and `ce_n` is low. With `cle`=1 and `ale`=0 the byte is a command. With `cle`=0 and `ale`=1 it is an address byte. Any other combination, or `ce_n`=1, has no effect on any output.
- R2: An accepted command sets `mode_o` as follows: opcode 0x00 gives 1 (lower half), 0x01 gives 2 (upper half) and 0x50 gives 3 (spare tail). Code 0 means no mode. Each read command restarts the address byte count.
- R3: On the first address byte N, `start_col_o` becomes N in mode 1 and 256+N in mode 2. In mode 3 it becomes 512 plus bits 3:0 of the byte, and bits 7:4 are ignored.
- R4: The second address byte is written to `page_o[7:0]` and the third to `page_o[15:8]`.
- R5: `start_req_o` is high for exactly one clock, at the edge that takes the third address byte. Further address bytes are then ignored until the next read command.
- R6: Address bytes taken while `mode_o` is 0 change no output and never raise `start_req_o`.
- R7: While `busy` is 1, a command other than 0xFF and every address byte are ignored: the mode, column and page stay as they were and no error is flagged.
- R8: Opcode 0xFF is accepted even while busy. It raises `rst_pulse_o` for one clock, sets `mode_o` to 0 and drops any address sequence in progress.
- R9: Any other opcode taken while not busy raises `cmd_err_o` for one clock and sets `mode_o` to 0.
- R10: While the synchronous `rst` is high, every output is driven to 0, and `mode_o` is 0 when it is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| ce_n | input | 1 | Chip select, active low |
| cle | input | 1 | Command latch enable |
| ale | input | 1 | Address latch enable |
| we_n | input | 1 | Write strobe, byte taken on its rising edge |
| io_in | input | 8 | Bus byte (command or address) |
| busy | input | 1 | Read engine busy |
| mode_o | output | 2 | Decoded read mode (0 none, 1 lower, 2 upper, 3 spare) |
| start_col_o | output | 10 | Absolute start column in the 528-byte page |
| page_o | output | 16 | Page index |
| start_req_o | output | 1 | One-clock start request to the read engine |
| rst_pulse_o | output | 1 | One-clock pulse on an accepted reset opcode |
| cmd_err_o | output | 1 | One-clock pulse on an unknown opcode |

## Verification
Full three-byte sequences are run in each of the three modes. The first byte is set to have its upper nibble high, which tells apart a spare-tail column that masks the nibble from one that adds the whole byte. Extra fourth bytes, address bytes without a mode, and a new command in the middle of a sequence each check the byte counter. Bytes sent with chip select high or with both latch enables set check the cycle qualification. Commands and addresses sent while busy, a reset opcode sent while busy, an unknown opcode and a mid-sequence synchronous reset check that state is held or cleared.

// File: rtl/nrom_pkg.sv
package nrom_pkg;

   typedef enum logic [1:0] {
      MODE_NONE  = 2'd0,
      MODE_LOW   = 2'd1,
      MODE_HIGH  = 2'd2,
      MODE_SPARE = 2'd3
   } rd_mode_e;

   localparam logic [7:0] OP_RD_LOW   = 8'h00;
   localparam logic [7:0] OP_RD_HIGH  = 8'h01;
   localparam logic [7:0] OP_RD_SPARE = 8'h50;
   localparam logic [7:0] OP_RESET    = 8'hFF;

endpackage

// File: rtl/nrom_strobe.sv
module nrom_strobe #(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             ce_n,
   input  logic             cle,
   input  logic             ale,
   input  logic             we_n,
   output logic             cmd_stb_o,
   output logic             addr_stb_o
);

   logic we_q;
   logic rise;

   always_ff @(posedge clk) begin
      if (rst) we_q <= 1'b1;
      else     we_q <= we_n;
   end

   assign rise       = we_n && !we_q && !ce_n;
   assign cmd_stb_o  = rise && cle && !ale;
   assign addr_stb_o = rise && !cle && ale;

   AST_STROBE_ON_RISE: assert property (@(posedge clk) disable iff (rst)
      (cmd_stb_o || addr_stb_o) |-> (we_n && !$past(we_n) && !ce_n)); // R1

endmodule

// File: rtl/nrom_cmd_decode.sv
module nrom_cmd_decode
   import nrom_pkg::*;
#(
   parameter int BUS_W = 8
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cmd_stb_i,
   input  logic [BUS_W-1:0] opcode_i,
   input  logic             busy_i,
   output rd_mode_e         mode_o,
   output logic             restart_o,
   output logic             rst_pulse_o,
   output logic             cmd_err_o
);

   localparam logic [BUS_W-1:0] C_RESET = BUS_W'(OP_RESET);
   localparam logic [BUS_W-1:0] C_LOW   = BUS_W'(OP_RD_LOW);
   localparam logic [BUS_W-1:0] C_HIGH  = BUS_W'(OP_RD_HIGH);
   localparam logic [BUS_W-1:0] C_SPARE = BUS_W'(OP_RD_SPARE);

   rd_mode_e mode_q;
   logic     rp_q;
   logic     err_q;
   logic     is_reset;

   assign is_reset  = (opcode_i == C_RESET);
   assign restart_o = cmd_stb_i && (is_reset || !busy_i);

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= MODE_NONE;
         rp_q   <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         rp_q  <= 1'b0;
         err_q <= 1'b0;
         if (cmd_stb_i) begin
            if (is_reset) begin
               mode_q <= MODE_NONE;
               rp_q   <= 1'b1;
            end else if (!busy_i) begin
               case (opcode_i)
                  C_LOW:   mode_q <= MODE_LOW;
                  C_HIGH:  mode_q <= MODE_HIGH;
                  C_SPARE: mode_q <= MODE_SPARE;
                  default: begin
                     mode_q <= MODE_NONE;
                     err_q  <= 1'b1;
                  end
               endcase
            end
         end
      end
   end

   assign mode_o      = mode_q;
   assign rst_pulse_o = rp_q;
   assign cmd_err_o   = err_q;

   AST_ERR_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
      cmd_err_o |-> (mode_o == MODE_NONE)); // R9
   AST_RESET_CLEARS_MODE: assert property (@(posedge clk) disable iff (rst)
      rst_pulse_o |-> (mode_o == MODE_NONE)); // R8
   AST_BUSY_KEEPS_MODE: assert property (@(posedge clk) disable iff (rst)
      (cmd_stb_i && busy_i && !is_reset) |=> ($stable(mode_o) && !cmd_err_o)); // R7
   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
      !(rst_pulse_o && cmd_err_o)); // R8

endmodule

// File: rtl/nrom_addr_asm.sv
module nrom_addr_asm
   import nrom_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int ADDR_CYCLES = 3,
   parameter int SPARE_W     = 4,
   parameter int COL_W       = BUS_W + 2,
   parameter int PAGE_W      = BUS_W * (ADDR_CYCLES - 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              addr_stb_i,
   input  logic [BUS_W-1:0]  data_i,
   input  logic              busy_i,
   input  logic              restart_i,
   input  rd_mode_e          mode_i,
   output logic [COL_W-1:0]  start_col_o,
   output logic [PAGE_W-1:0] page_o,
   output logic              start_req_o
);

   localparam int CNT_W = $clog2(ADDR_CYCLES + 1);
   localparam logic [COL_W-1:0] HIGH_BASE  = COL_W'(1) << BUS_W;
   localparam logic [COL_W-1:0] SPARE_BASE = COL_W'(2) << BUS_W;

   logic [CNT_W-1:0]  cnt_q;
   logic [COL_W-1:0]  col_q;
   logic [COL_W-1:0]  col_next;
   logic [PAGE_W-1:0] page_q;
   logic              start_q;
   logic              accept;

   assign accept = addr_stb_i && !busy_i && (mode_i != MODE_NONE) &&
                   (cnt_q < CNT_W'(ADDR_CYCLES));

   always_comb begin
      case (mode_i)
         MODE_LOW:   col_next = COL_W'(data_i);
         MODE_HIGH:  col_next = COL_W'(data_i) + HIGH_BASE;
         MODE_SPARE: col_next = COL_W'(data_i[SPARE_W-1:0]) + SPARE_BASE;
         default:    col_next = col_q;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q   <= '0;
         col_q   <= '0;
         start_q <= 1'b0;
      end else begin
         start_q <= 1'b0;
         if (restart_i) begin
            cnt_q <= '0;
         end else if (accept) begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == '0) col_q <= col_next;
            if (cnt_q == CNT_W'(ADDR_CYCLES - 1)) start_q <= 1'b1;
         end
      end
   end

   for (genvar i = 1; i < ADDR_CYCLES; i++) begin : g_page_byte
      always_ff @(posedge clk) begin
         if (rst)
            page_q[(i-1)*BUS_W +: BUS_W] <= '0;
         else if (!restart_i && accept && (cnt_q == CNT_W'(i)))
            page_q[(i-1)*BUS_W +: BUS_W] <= data_i;
      end
   end

   assign start_col_o = col_q;
   assign page_o      = page_q;
   assign start_req_o = start_q;

   AST_START_SINGLE: assert property (@(posedge clk) disable iff (rst)
      start_req_o |=> !start_req_o); // R5
   AST_START_HAS_MODE: assert property (@(posedge clk) disable iff (rst)
      start_req_o |-> (mode_i != MODE_NONE)); // R6
   AST_SPARE_COL_RANGE: assert property (@(posedge clk) disable iff (rst)
      (start_req_o && mode_i == MODE_SPARE) |->
      (start_col_o >= SPARE_BASE && start_col_o < SPARE_BASE + COL_W'(1 << SPARE_W))); // R3
   AST_BUSY_NO_CAPTURE: assert property (@(posedge clk) disable iff (rst)
      (busy_i && addr_stb_i) |=> ($stable(start_col_o) && $stable(page_o) && !start_req_o)); // R7

endmodule

// File: rtl/nrom_cmd_front.sv
module nrom_cmd_front
   import nrom_pkg::*;
#(
   parameter int BUS_W       = 8,
   parameter int ADDR_CYCLES = 3,
   parameter int SPARE_W     = 4,
   localparam int COL_W      = BUS_W + 2,
   localparam int PAGE_W     = BUS_W * (ADDR_CYCLES - 1)
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              ce_n,
   input  logic              cle,
   input  logic              ale,
   input  logic              we_n,
   input  logic [BUS_W-1:0]  io_in,
   input  logic              busy,
   output logic [1:0]        mode_o,
   output logic [COL_W-1:0]  start_col_o,
   output logic [PAGE_W-1:0] page_o,
   output logic              start_req_o,
   output logic              rst_pulse_o,
   output logic              cmd_err_o
);

   if (BUS_W < 8) begin : g_bad_bus
      $error("nrom_cmd_front: BUS_W must be at least 8");
   end
   if (ADDR_CYCLES < 2) begin : g_bad_cycles
      $error("nrom_cmd_front: ADDR_CYCLES must be at least 2");
   end
   if (SPARE_W < 1 || SPARE_W > BUS_W) begin : g_bad_spare
      $error("nrom_cmd_front: SPARE_W must lie in 1..BUS_W");
   end

   logic     cmd_stb;
   logic     addr_stb;
   logic     restart;
   rd_mode_e mode;

   nrom_strobe #(.BUS_W(BUS_W)) u_strobe (
      .clk        (clk),
      .rst        (rst),
      .ce_n       (ce_n),
      .cle        (cle),
      .ale        (ale),
      .we_n       (we_n),
      .cmd_stb_o  (cmd_stb),
      .addr_stb_o (addr_stb)
   );

   nrom_cmd_decode #(.BUS_W(BUS_W)) u_decode (
      .clk         (clk),
      .rst         (rst),
      .cmd_stb_i   (cmd_stb),
      .opcode_i    (io_in),
      .busy_i      (busy),
      .mode_o      (mode),
      .restart_o   (restart),
      .rst_pulse_o (rst_pulse_o),
      .cmd_err_o   (cmd_err_o)
   );

   nrom_addr_asm #(
      .BUS_W       (BUS_W),
      .ADDR_CYCLES (ADDR_CYCLES),
      .SPARE_W     (SPARE_W),
      .COL_W       (COL_W),
      .PAGE_W      (PAGE_W)
   ) u_addr (
      .clk         (clk),
      .rst         (rst),
      .addr_stb_i  (addr_stb),
      .data_i      (io_in),
      .busy_i      (busy),
      .restart_i   (restart),
      .mode_i      (mode),
      .start_col_o (start_col_o),
      .page_o      (page_o),
      .start_req_o (start_req_o)
   );

   assign mode_o = mode;

   AST_RESET_IDLE: assert property (@(posedge clk)
      $past(rst) |-> (mode_o == 2'd0 && !start_req_o && !rst_pulse_o && !cmd_err_o)); // R10

endmodule

// File: tb/nrom_cmd_front_bench.sv
`timescale 1ns/1ps
module nrom_cmd_front_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        ce_n = 1'b1, cle = 1'b0, ale = 1'b0, we_n = 1'b1, busy = 1'b0;
   logic [7:0]  io = 8'h00;
   logic [1:0]  mode_o;
   logic [9:0]  start_col_o;
   logic [15:0] page_o;
   logic        start_req_o, rst_pulse_o, cmd_err_o;

   int errors = 0;
   int checks = 0;
   bit started = 1'b0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   nrom_cmd_front u_nrom_cmd_front (
      .clk(clk), .rst(rst), .ce_n(ce_n), .cle(cle), .ale(ale), .we_n(we_n),
      .io_in(io), .busy(busy), .mode_o(mode_o), .start_col_o(start_col_o),
      .page_o(page_o), .start_req_o(start_req_o), .rst_pulse_o(rst_pulse_o),
      .cmd_err_o(cmd_err_o)
   );

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // behavioural reference model
   int       m_mode = 0, m_col = 0, m_page = 0;
   bit       m_start = 0, m_rp = 0, m_err = 0, m_prev_we = 1;
   bit [7:0] m_bytes[$];

   always @(posedge clk) begin
      started <= 1'b1;
      m_start = 0; m_rp = 0; m_err = 0;
      if (rst) begin
         m_mode = 0; m_col = 0; m_page = 0; m_prev_we = 1; m_bytes.delete();
      end else begin
         if (we_n && !m_prev_we && !ce_n) begin
            if (cle && !ale) begin
               if (io == 8'hFF) begin
                  m_rp = 1; m_mode = 0; m_bytes.delete();
               end else if (!busy) begin
                  m_bytes.delete();
                  if (io == 8'h00) m_mode = 1;
                  else if (io == 8'h01) m_mode = 2;
                  else if (io == 8'h50) m_mode = 3;
                  else begin m_mode = 0; m_err = 1; end
               end
            end else if (!cle && ale && !busy && m_mode != 0 && m_bytes.size() < 3) begin
               m_bytes.push_back(io);
               if (m_bytes.size() == 1) begin
                  if (m_mode == 1) m_col = io;
                  else if (m_mode == 2) m_col = 256 + io;
                  else m_col = 512 + (io & 8'h0F);
               end else if (m_bytes.size() == 2) begin
                  m_page = (m_page & 16'hFF00) | io;
               end else begin
                  m_page = (m_page & 16'h00FF) | (int'(io) << 8);
                  m_start = 1;
               end
            end
         end
         m_prev_we = we_n;
      end
   end

   always @(negedge clk) begin
      if (started && !done) begin
         chk("R2 mode vs model", mode_o, m_mode);
         chk("R3 column vs model", start_col_o, m_col);
         chk("R4 page vs model", page_o, m_page);
         chk("R5 start vs model", start_req_o, m_start);
         chk("R8 reset pulse vs model", rst_pulse_o, m_rp);
         chk("R9 error vs model", cmd_err_o, m_err);
      end
   end

   task automatic bus(input logic c, input logic a, input logic n, input logic [7:0] d);
      cle = c; ale = a; ce_n = n; io = d; we_n = 1'b0;
      @(negedge clk);
      we_n = 1'b1;
      @(negedge clk);
   endtask

   task automatic cmd(input logic [7:0] d); bus(1'b1, 1'b0, 1'b0, d); endtask
   task automatic adr(input logic [7:0] d); bus(1'b0, 1'b1, 1'b0, d); endtask
   task automatic idle(input int n); repeat (n) @(negedge clk); endtask

   initial begin
      repeat (100000) @(posedge clk);
      done = 1'b1;
      errors++; checks++;
      $display("FAIL watchdog: actual=expired expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R10 mode in reset", mode_o, 0);
      chk("R10 start in reset", start_req_o, 0);
      chk("R10 column in reset", start_col_o, 0);
      rst = 1'b0;
      idle(2);

      // lower half
      cmd(8'h00);
      chk("R2 mode lower", mode_o, 1);
      adr(8'h37); adr(8'h12); adr(8'hAB);
      chk("R5 start pulse", start_req_o, 1);
      chk("R3 column lower", start_col_o, 8'h37);
      chk("R4 page", page_o, 16'hAB12);
      idle(1);
      chk("R5 start drops", start_req_o, 0);
      adr(8'h99);
      chk("R5 extra byte no start", start_req_o, 0);
      chk("R5 extra byte column held", start_col_o, 8'h37);

      // upper half
      cmd(8'h01); adr(8'hFF); adr(8'h00); adr(8'h01);
      chk("R3 column upper", start_col_o, 511);
      chk("R4 page upper", page_o, 16'h0100);
      chk("R5 start upper", start_req_o, 1);

      // spare tail, upper nibble masked
      cmd(8'h50); adr(8'hF5);
      chk("R3 spare masks nibble", start_col_o, 517);
      adr(8'h34); adr(8'h56);
      chk("R5 start spare", start_req_o, 1);
      cmd(8'h50); adr(8'h0F); adr(8'h00); adr(8'h00);
      chk("R3 spare last column", start_col_o, 527);

      // qualification
      bus(1'b1, 1'b0, 1'b1, 8'h01);
      chk("R1 ce high ignored", mode_o, 3);
      bus(1'b1, 1'b1, 1'b0, 8'h00);
      chk("R1 both latches ignored", mode_o, 3);

      // restart mid-sequence
      cmd(8'h00); adr(8'h11); adr(8'h22);
      cmd(8'h01); adr(8'h05); adr(8'h06); adr(8'h07);
      chk("R2 restart column", start_col_o, 261);
      chk("R2 restart start", start_req_o, 1);

      // reset opcode
      cmd(8'hFF);
      chk("R8 pulse", rst_pulse_o, 1);
      chk("R8 mode cleared", mode_o, 0);
      adr(8'h44); adr(8'h55); adr(8'h66);
      chk("R6 no start without mode", start_req_o, 0);
      chk("R6 column held", start_col_o, 261);

      // abandon sequence
      cmd(8'h00); adr(8'h21); cmd(8'hFF); adr(8'h22); adr(8'h23);
      chk("R8 abandoned sequence no start", start_req_o, 0);

      // unknown opcode
      cmd(8'h01);
      cmd(8'h30);
      chk("R9 error pulse", cmd_err_o, 1);
      chk("R9 mode cleared", mode_o, 0);
      idle(1);
      chk("R9 error drops", cmd_err_o, 0);

      // busy
      cmd(8'h00); adr(8'h08);
      busy = 1'b1;
      cmd(8'h50);
      chk("R7 command ignored while busy", mode_o, 1);
      chk("R7 no error while busy", cmd_err_o, 0);
      cmd(8'h77);
      chk("R7 unknown ignored while busy", cmd_err_o, 0);
      adr(8'h09); adr(8'h0A);
      chk("R7 address ignored while busy", start_req_o, 0);
      busy = 1'b0;
      adr(8'h0B); adr(8'h0C);
      chk("R7 sequence resumes", start_req_o, 1);
      chk("R7 page after busy", page_o, 16'h0C0B);
      busy = 1'b1;
      cmd(8'hFF);
      chk("R8 reset accepted while busy", rst_pulse_o, 1);
      busy = 1'b0;

      // synchronous reset mid-sequence
      cmd(8'h01); adr(8'h03);
      rst = 1'b1;
      idle(1);
      rst = 1'b0;
      chk("R10 mode after reset", mode_o, 0);
      chk("R10 column after reset", start_col_o, 0);
      adr(8'h04); adr(8'h05);
      chk("R10 no start after reset", start_req_o, 0);
      idle(2);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule